// File: doc/BRIEF.md
# Instruction Group Issue Sequencer

This block sits between an instruction fetch queue and an N-wide issue stage. Fetch delivers bundles of three syllables over a valid/ready handshake. Each syllable carries a stop flag, and that flag closes the instruction group the syllable belongs to. Syllables are held in a small circular staging buffer. A group is sent to the issue port up to N syllables per cycle, in program order. An issue cycle never holds syllables from two different groups, and a group may run across bundle boundaries.

All operands of a group are read as of the moment the group begins. So no syllable in a group may read a register that another syllable of the same group writes, and no two syllables of a group may write the same register. The sequencer tracks the registers read and written by the open group across all of that group's issue cycles. If the compiler broke either rule, a violation flag pulses once after the group has finished issuing. Issue goes on regardless of the flag.

Top module: `igs_top`

## Requirements
- R1: `bnd_rdy_o` is high exactly when the staging buffer holds no more than BUF_DEPTH-3 syllables. A bundle is taken on a clock edge where `bnd_vld_i` and `bnd_rdy_o` are both high.
- R2: Syllable k of a bundle (k = 0, 1, 2, with 0 the earliest in program order) sits at bits [23k+22:23k]. Within a syllable, bit 22 is stop, bit 21 marks the destination as valid, bits 20:14 are the destination, 13:7 are source A and 6:0 are source B. Issue slot i uses the same layout at bits [23i+22:23i].
- R3: Issued syllables fill slots from slot 0 in program order, with no gaps. The valid slots of one cycle all belong to one group: a syllable with stop set is always the last valid slot of its cycle.
- R4: The block issues only when it holds at least ISSUE_W syllables or when the stop that closes the group lies within the first ISSUE_W held syllables. Otherwise all slot valids stay low. A group of L syllables fed back to back takes ceil(L/ISSUE_W) issue cycles.
- R5: A group may span bundles. Syllables left over from one bundle issue together with syllables of the next bundle.
- R6: If a syllable reads (through source A or B) a register that another syllable of the same group writes, `hz_o` is high for exactly the one cycle after the group's final issue cycle. This holds whichever syllable comes first and whether or not both issue in the same cycle.
- R7: If two syllables of one group both write the same register, `hz_o` is raised in the same way as in R6.
- R8: A destination whose valid bit is 0 takes part in no check. A syllable that reads its own destination raises no flag. Syllables in different groups never raise the flag.
- R9: A group that raises the flag still issues with the same slot pattern as a group without conflicts.
- R10: During and right after reset, no slot is valid, `hz_o` is low, `bnd_rdy_o` is high and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bnd_vld_i | input | 1 | Bundle offered by fetch |
| bnd_rdy_o | output | 1 | Buffer has room for a whole bundle |
| bnd_i | input | 69 | Three syllables, slot 0 in the low bits |
| iss_vld_o | output | ISSUE_W | Per-slot issue valid |
| iss_syl_o | output | 23*ISSUE_W | Issued syllables; invalid slots read as zero |
| hz_o | output | 1 | In-group register conflict, one-cycle pulse |

## Verification
The hardest state to reach from the ports is a group that is cut at a bundle edge. In that state one syllable sits alone in the buffer with no stop and must wait, and a register conflict links it to a syllable that arrives later. The stimulus builds this state directly. It sends a bundle with no stop, checks that issue stops with one syllable held back, and then sends a bundle whose first syllable reads the held syllable's destination and closes the group. A separate stream of three bundles with no stop until the end pushes the buffer past its threshold. This makes ready fall, and the stimulus checks ready against an occupancy count built from the handshakes and issue valids seen at the ports.

// File: rtl/igs_pkg.sv
`timescale 1ns/1ps
package igs_pkg;
   localparam int IGS_REG_W = 7;
   localparam int BUNDLE_N  = 3;

   typedef struct packed {
      logic                 stop;
      logic                 dvld;
      logic [IGS_REG_W-1:0] dst;
      logic [IGS_REG_W-1:0] src_a;
      logic [IGS_REG_W-1:0] src_b;
   } syl_t;

   localparam int SYL_W = $bits(syl_t);
endpackage

// File: rtl/igs_stage.sv
`timescale 1ns/1ps
// Circular syllable store: one bundle in, a variable count out, window view of the head.
module igs_stage
   import igs_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int WIN   = 2,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  syl_t             push_syl [BUNDLE_N],
   input  logic [CNT_W-1:0] pop_n,
   output syl_t             win [WIN],
   output logic [CNT_W-1:0] cnt
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   syl_t             mem [DEPTH];
   logic [PTR_W-1:0] rd_q, wr_q;

   function automatic logic [PTR_W-1:0] wrap(input int p);
      return PTR_W'(p % DEPTH);
   endfunction

   always_ff @(posedge clk) begin
      if (push) begin
         for (int k = 0; k < BUNDLE_N; k++) begin
            mem[wrap(int'(wr_q) + k)] <= push_syl[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q <= '0;
         wr_q <= '0;
         cnt  <= '0;
      end else begin
         if (push) wr_q <= wrap(int'(wr_q) + BUNDLE_N);
         rd_q <= wrap(int'(rd_q) + int'(pop_n));
         cnt  <= cnt + (push ? CNT_W'(BUNDLE_N) : '0) - pop_n;
      end
   end

   always_comb begin
      for (int i = 0; i < WIN; i++) begin
         win[i] = mem[wrap(int'(rd_q) + i)];
      end
   end
endmodule

// File: rtl/igs_pick.sv
`timescale 1ns/1ps
// Decides how many head syllables go out this cycle: up to the group stop, or a full window.
module igs_pick
   import igs_pkg::*;
#(
   parameter int WIN   = 2,
   parameter int CNT_W = 3
) (
   input  syl_t             win [WIN],
   input  logic [CNT_W-1:0] cnt,
   output logic [WIN-1:0]   vld,
   output logic [CNT_W-1:0] take,
   output logic             closes
);
   always_comb begin
      closes = 1'b0;
      take   = '0;
      for (int i = 0; i < WIN; i++) begin
         if (!closes && (cnt > CNT_W'(i)) && win[i].stop) begin
            closes = 1'b1;
            take   = CNT_W'(i + 1);
         end
      end
      if (!closes && (cnt >= CNT_W'(WIN))) take = CNT_W'(WIN);
      for (int i = 0; i < WIN; i++) begin
         vld[i] = (CNT_W'(i) < take);
      end
   end
endmodule

// File: rtl/igs_hazard.sv
`timescale 1ns/1ps
// Tracks registers read and written by the open group; pulses on RAW or WAW when it closes.
module igs_hazard
   import igs_pkg::*;
#(
   parameter int WIN = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  syl_t           slot [WIN],
   input  logic [WIN-1:0] vld,
   input  logic           closes,
   output logic           hz
);
   localparam int NREG = 1 << IGS_REG_W;

   logic [NREG-1:0] wr_m, rd_m, wr_n, rd_n;
   logic            acc_q, bad;

   always_comb begin
      bad  = 1'b0;
      wr_n = wr_m;
      rd_n = rd_m;
      for (int i = 0; i < WIN; i++) begin
         if (vld[i]) begin
            if (wr_m[slot[i].src_a] || wr_m[slot[i].src_b]) bad = 1'b1;
            if (slot[i].dvld && (rd_m[slot[i].dst] || wr_m[slot[i].dst])) bad = 1'b1;
            for (int j = 0; j < WIN; j++) begin
               if (vld[j] && (j != i)) begin
                  if (slot[j].dvld && ((slot[j].dst == slot[i].src_a) ||
                                       (slot[j].dst == slot[i].src_b))) bad = 1'b1;
                  if ((j > i) && slot[i].dvld && slot[j].dvld &&
                      (slot[i].dst == slot[j].dst)) bad = 1'b1;
               end
            end
            rd_n[slot[i].src_a] = 1'b1;
            rd_n[slot[i].src_b] = 1'b1;
            if (slot[i].dvld) wr_n[slot[i].dst] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_m  <= '0;
         rd_m  <= '0;
         acc_q <= 1'b0;
         hz    <= 1'b0;
      end else if (closes) begin
         wr_m  <= '0;
         rd_m  <= '0;
         acc_q <= 1'b0;
         hz    <= acc_q | bad;
      end else begin
         hz <= 1'b0;
         if (|vld) begin
            wr_m  <= wr_n;
            rd_m  <= rd_n;
            acc_q <= acc_q | bad;
         end
      end
   end
endmodule

// File: rtl/igs_top.sv
`timescale 1ns/1ps
module igs_top
   import igs_pkg::*;
#(
   parameter int ISSUE_W   = 2,
   parameter int BUF_DEPTH = 6
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       bnd_vld_i,
   output logic                       bnd_rdy_o,
   input  logic [BUNDLE_N*SYL_W-1:0]  bnd_i,
   output logic [ISSUE_W-1:0]         iss_vld_o,
   output logic [ISSUE_W*SYL_W-1:0]   iss_syl_o,
   output logic                       hz_o
);
   localparam int CNT_W = $clog2(BUF_DEPTH + 1);

   generate
      if (ISSUE_W < 1 || BUF_DEPTH < BUNDLE_N || BUF_DEPTH < ISSUE_W + 2) begin : g_bad_cfg
         $error("igs_top: BUF_DEPTH must be at least max(3, ISSUE_W+2)");
      end
   endgenerate

   syl_t             syl_in [BUNDLE_N];
   syl_t             win    [ISSUE_W];
   logic [CNT_W-1:0] cnt, take;
   logic             closes, push;

   always_comb begin
      for (int k = 0; k < BUNDLE_N; k++) begin
         syl_in[k] = syl_t'(bnd_i[k*SYL_W +: SYL_W]);
      end
   end

   assign bnd_rdy_o = (cnt <= CNT_W'(BUF_DEPTH - BUNDLE_N));
   assign push      = bnd_vld_i & bnd_rdy_o;

   igs_stage #(.DEPTH(BUF_DEPTH), .WIN(ISSUE_W), .CNT_W(CNT_W)) u_stage (
      .clk(clk), .rst(rst), .push(push), .push_syl(syl_in),
      .pop_n(take), .win(win), .cnt(cnt)
   );

   igs_pick #(.WIN(ISSUE_W), .CNT_W(CNT_W)) u_pick (
      .win(win), .cnt(cnt), .vld(iss_vld_o), .take(take), .closes(closes)
   );

   igs_hazard #(.WIN(ISSUE_W)) u_hazard (
      .clk(clk), .rst(rst), .slot(win), .vld(iss_vld_o),
      .closes(closes), .hz(hz_o)
   );

   generate
      for (genvar i = 0; i < ISSUE_W; i++) begin : g_slot
         assign iss_syl_o[i*SYL_W +: SYL_W] = iss_vld_o[i] ? win[i] : '0;
      end
   endgenerate
endmodule

// File: rtl/igs_chk.sv
`timescale 1ns/1ps
module igs_chk #(
   parameter int ISSUE_W = 2,
   parameter int SYL_W   = 23
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     bnd_rdy_o,
   input logic [ISSUE_W-1:0]       iss_vld_o,
   input logic [ISSUE_W*SYL_W-1:0] iss_syl_o,
   input logic                     hz_o
);
   logic [ISSUE_W-1:0] st;
   logic               close, mix;

   always_comb begin
      mix = 1'b0;
      for (int i = 0; i < ISSUE_W; i++) st[i] = iss_syl_o[i*SYL_W + SYL_W - 1];
      for (int i = 0; i + 1 < ISSUE_W; i++) begin
         if (iss_vld_o[i] && st[i] && iss_vld_o[i+1]) mix = 1'b1;
      end
   end
   assign close = |(iss_vld_o & st);

   AST_RST_IDLE: assert property (@(posedge clk) rst |=> (iss_vld_o == '0 && !hz_o && bnd_rdy_o)); // R10
   AST_VLD_PREFIX: assert property (@(posedge clk) disable iff (rst)
      ((iss_vld_o & (iss_vld_o + 1'b1)) == '0)); // R3
   AST_ONE_GROUP: assert property (@(posedge clk) disable iff (rst) !mix); // R3
   AST_FULL_OR_CLOSE: assert property (@(posedge clk) disable iff (rst)
      (|iss_vld_o) |-> ((&iss_vld_o) || close)); // R4
   AST_HZ_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
      hz_o |-> $past(close)); // R6
endmodule

bind igs_top igs_chk #(.ISSUE_W(ISSUE_W), .SYL_W(SYL_W)) u_chk (
   .clk(clk), .rst(rst), .bnd_rdy_o(bnd_rdy_o), .iss_vld_o(iss_vld_o),
   .iss_syl_o(iss_syl_o), .hz_o(hz_o)
);

// File: tb/tb_igs_top.sv
`timescale 1ns/1ps
module tb_igs_top;
   localparam int N     = 2;
   localparam int DEPTH = 6;
   localparam int SW    = 23;

   function automatic logic [SW-1:0] sy(input bit st, input bit dv, input int d, input int a, input int b);
      return {st, dv, 7'(d), 7'(a), 7'(b)};
   endfunction
   function automatic logic [3*SW-1:0] bn(input logic [SW-1:0] s0, input logic [SW-1:0] s1, input logic [SW-1:0] s2);
      return {s2, s1, s0};
   endfunction

   typedef struct packed {
      logic [3*SW-1:0] bnd;
      logic [7:0]      vld;   // {c3,c2,c1,c0}, two slot bits per sample
      logic [3:0]      hz;    // {c3,c2,c1,c0}
      logic [3:0]      req;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      // R3 R4: one group of three, 2 then 1
      '{bnd: bn(sy(0,1,1,10,11), sy(0,1,2,12,13), sy(1,1,3,14,15)), vld: 8'b00_00_01_11, hz: 4'b0000, req: 4'd4},
      // R3: each syllable its own group
      '{bnd: bn(sy(1,1,1,10,11), sy(1,1,2,12,13), sy(1,1,3,14,15)), vld: 8'b00_01_01_01, hz: 4'b0000, req: 4'd3},
      // R6 R9: RAW inside one issue cycle
      '{bnd: bn(sy(0,1,5,10,11), sy(0,1,2,5,13), sy(1,1,3,14,15)), vld: 8'b00_00_01_11, hz: 4'b0100, req: 4'd6},
      // R6 R9: RAW across issue cycles
      '{bnd: bn(sy(0,1,6,10,11), sy(0,1,2,12,13), sy(1,1,3,14,6)), vld: 8'b00_00_01_11, hz: 4'b0100, req: 4'd6},
      // R7 R9: WAW across issue cycles
      '{bnd: bn(sy(0,1,7,10,11), sy(0,1,2,12,13), sy(1,1,7,14,15)), vld: 8'b00_00_01_11, hz: 4'b0100, req: 4'd7},
      // R6: read first, write later
      '{bnd: bn(sy(0,1,1,8,11), sy(0,1,2,12,13), sy(1,1,8,14,15)), vld: 8'b00_00_01_11, hz: 4'b0100, req: 4'd6},
      // R8: syllables reading their own destination
      '{bnd: bn(sy(0,1,9,9,11), sy(0,1,2,12,2), sy(1,1,3,3,15)), vld: 8'b00_00_01_11, hz: 4'b0000, req: 4'd8},
      // R8: destination with valid bit 0 ignored
      '{bnd: bn(sy(0,0,20,10,11), sy(0,1,2,20,13), sy(1,0,20,14,15)), vld: 8'b00_00_01_11, hz: 4'b0000, req: 4'd8},
      // R8: reuse across a group boundary is legal
      '{bnd: bn(sy(1,1,4,10,11), sy(0,1,4,4,13), sy(1,1,30,14,15)), vld: 8'b00_00_11_01, hz: 4'b0000, req: 4'd8},
      // R6 R3: conflict in first of two groups, pulse one cycle
      '{bnd: bn(sy(0,1,3,10,11), sy(1,1,2,3,13), sy(1,1,5,14,15)), vld: 8'b00_00_01_11, hz: 4'b0010, req: 4'd6}
   };

   logic              clk = 1'b0, rst = 1'b1, bnd_vld_i = 1'b0;
   logic [3*SW-1:0]   bnd_i = '0;
   logic              bnd_rdy_o, hz_o;
   logic [N-1:0]      iss_vld_o;
   logic [N*SW-1:0]   iss_syl_o;
   int                n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   igs_top #(.ISSUE_W(N), .BUF_DEPTH(DEPTH)) dut (
      .clk(clk), .rst(rst), .bnd_vld_i(bnd_vld_i), .bnd_rdy_o(bnd_rdy_o), .bnd_i(bnd_i),
      .iss_vld_o(iss_vld_o), .iss_syl_o(iss_syl_o), .hz_o(hz_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int occ, sent, icyc, isyl;
      bit lowseen;
      logic [3*SW-1:0] pb, qb, cb;
      repeat (3) @(negedge clk);
      chk(iss_vld_o == '0 && !hz_o && bnd_rdy_o, "R10", "state in reset",
          {iss_vld_o, hz_o, bnd_rdy_o}, 64'b001);
      rst = 1'b0;
      @(negedge clk);
      chk(iss_vld_o == '0 && !hz_o && bnd_rdy_o, "R10", "state after reset",
          {iss_vld_o, hz_o, bnd_rdy_o}, 64'b001);

      // table walk
      for (int v = 0; v < NV; v++) begin
         bnd_vld_i = 1'b1;
         bnd_i     = VECS[v].bnd;
         @(negedge clk);
         bnd_vld_i = 1'b0;
         for (int c = 0; c < 4; c++) begin
            chk(iss_vld_o == VECS[v].vld[2*c +: 2], $sformatf("R%0d", VECS[v].req),
                $sformatf("vec %0d sample %0d slot valid", v, c), iss_vld_o, VECS[v].vld[2*c +: 2]);
            chk(hz_o == VECS[v].hz[c], $sformatf("R%0d", VECS[v].req),
                $sformatf("vec %0d sample %0d flag", v, c), hz_o, VECS[v].hz[c]);
            if (c == 0) begin
               for (int i = 0; i < N; i++) begin
                  if (VECS[v].vld[i]) // R2 field and slot order
                     chk(iss_syl_o[i*SW +: SW] == VECS[v].bnd[i*SW +: SW], "R2",
                         $sformatf("vec %0d slot %0d data", v, i),
                         iss_syl_o[i*SW +: SW], VECS[v].bnd[i*SW +: SW]);
               end
            end
            @(negedge clk);
         end
      end

      // R4 R5 R6: stranded syllable, group spans bundles, RAW across the edge
      pb = bn(sy(0,1,50,101,102), sy(0,1,51,103,104), sy(0,1,40,105,106));
      qb = bn(sy(1,0,0,40,107), sy(0,1,52,108,109), sy(1,1,53,110,111));
      bnd_vld_i = 1'b1; bnd_i = pb;
      @(negedge clk);
      bnd_vld_i = 1'b0;
      chk(iss_vld_o == 2'b11, "R4", "first pair of open group", iss_vld_o, 2'b11);
      @(negedge clk);
      chk(iss_vld_o == 2'b00, "R4", "single held syllable waits", iss_vld_o, 2'b00);
      @(negedge clk);
      chk(iss_vld_o == 2'b00, "R4", "still waiting", iss_vld_o, 2'b00);
      bnd_vld_i = 1'b1; bnd_i = qb;
      @(negedge clk);
      bnd_vld_i = 1'b0;
      chk(iss_vld_o == 2'b11, "R5", "pair across bundle edge", iss_vld_o, 2'b11);
      chk(iss_syl_o[0 +: SW] == pb[2*SW +: SW], "R5", "slot0 is leftover", iss_syl_o[0 +: SW], pb[2*SW +: SW]);
      chk(iss_syl_o[SW +: SW] == qb[0 +: SW], "R5", "slot1 is next bundle head", iss_syl_o[SW +: SW], qb[0 +: SW]);
      chk(!hz_o, "R6", "no flag before close", hz_o, 0);
      @(negedge clk);
      chk(hz_o, "R6", "flag after spanning group", hz_o, 1);
      chk(iss_vld_o == 2'b11, "R9", "next group issues", iss_vld_o, 2'b11);
      @(negedge clk);
      chk(!hz_o, "R6", "flag lasts one cycle", hz_o, 0);
      chk(iss_vld_o == 2'b00, "R3", "buffer drained", iss_vld_o, 2'b00);

      // R1 R4: nine-syllable group streamed, back-pressure tracked from ports
      occ = 0; sent = 0; icyc = 0; isyl = 0; lowseen = 0;
      for (int t = 0; t < 20; t++) begin
         cb = (sent == 2) ? bn(sy(0,0,0,1,2), sy(0,0,0,3,4), sy(1,0,0,5,6))
                          : bn(sy(0,0,0,1,2), sy(0,0,0,3,4), sy(0,0,0,5,6));
         bnd_vld_i = (sent < 3);
         bnd_i     = cb;
         #1;
         chk(bnd_rdy_o == (occ <= DEPTH - 3), "R1", $sformatf("ready at cycle %0d", t),
             bnd_rdy_o, (occ <= DEPTH - 3));
         if (!bnd_rdy_o) lowseen = 1;
         if (|iss_vld_o) icyc++;
         isyl += $countones(iss_vld_o);
         occ  += ((bnd_vld_i && bnd_rdy_o) ? 3 : 0) - $countones(iss_vld_o);
         if (bnd_vld_i && bnd_rdy_o) sent++;
         @(negedge clk);
      end
      bnd_vld_i = 1'b0;
      chk(lowseen, "R1", "ready dropped under load", lowseen, 1);
      chk(isyl == 9, "R4", "syllables issued", isyl, 9);
      chk(icyc == 5, "R4", "issue cycles for nine", icyc, 5);
      finish_run();
   end
endmodule